// File: doc/BRIEF.md
# Light-Level Interrupt Controller with Persistence

This block sits between a light-measurement converter and the register file of a sensor chip. Each time a new conversion result is announced by a one-cycle strobe, it decides whether that result counts as an interrupt-worthy event. It then drives a sticky status flag and an active-low interrupt pin.

Two trigger styles are available. In window mode a result counts when it leaves the band set by a lower and an upper 20-bit limit. In delta mode a result counts when it differs from the previous result by more than a step of 8 shifted left by a 3-bit code. A programmable persistence count demands several consecutive counting results before the flag is raised.

The compared value is taken from one of two converter channels. The flag is cleared by a one-cycle pulse that the register file issues when software reads the status. The pin is modelled as the level of an open-drain output: 0 means pulled low (asserted) and 1 means released.

Top module: `light_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq_flag` is 0 and `irq_n` is 1.
- R2: While `irq_en` is 0, no sample sets the flag, and the consecutive-sample count is held at zero.
- R3: With `var_mode` = 0, an enabled sample counts when the selected value is strictly greater than `thr_hi` or strictly less than `thr_lo`; values equal to a limit do not count.
- R4: With `var_mode` = 1, an enabled sample counts when the absolute difference between it and the previous enabled sample is strictly greater than 8 << `var_code` (code 0 gives 8, code 7 gives 1024). Rising and falling changes are treated alike.
- R5: In delta mode, the first enabled sample after `irq_en` rises or after `var_mode` changes never counts; it only stores the reference value.
- R6: The flag sets on the (`persist`+1)-th consecutive counting sample. A non-counting enabled sample returns the count to zero. The count saturates at its target, so every further counting sample keeps setting the flag.
- R7: `src_sel` = 2'b00 compares `clear_data`; every other code (2'b01 is the intended one) compares `als_data`.
- R8: A `stat_rd_clr` pulse clears the flag on the next edge. If a setting sample is taken in the same cycle, the set wins and the flag stays 1.
- R9: `irq_n` is 0 exactly when the flag is 1 and `irq_en` is 1. Dropping `irq_en` releases the pin at once, and the flag keeps its value.
- R10: A setting sample presented with `sample_vld` in one cycle shows on `irq_flag` right after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | One-cycle strobe marking a new conversion result |
| clear_data | input | 20 | Result of the unfiltered channel |
| als_data | input | 20 | Result of the eye-response channel |
| irq_en | input | 1 | Interrupt logic enable |
| var_mode | input | 1 | 0 = window mode, 1 = delta mode |
| src_sel | input | 2 | Channel select: 00 clear channel, otherwise eye-response channel |
| persist | input | 4 | Consecutive counting samples needed, minus one |
| thr_hi | input | 20 | Upper window limit |
| thr_lo | input | 20 | Lower window limit |
| var_code | input | 3 | Delta step code, step = 8 << code |
| stat_rd_clr | input | 1 | One-cycle pulse from a status read, clears the flag |
| irq_flag | output | 1 | Sticky interrupt status |
| irq_n | output | 1 | Interrupt pin level, 0 = asserted |

## Verification
The flag set by a new counting sample and the flag clear from a status read can land on the same clock edge. The bench provokes this by presenting a delta-mode sample that exceeds the step together with a `stat_rd_clr` pulse. It expects the flag to stay 1 and only fall on a later lone clear. A second overlap occurs when a mode change and a sample coincide: that sample must only re-arm the reference. Both outcomes are judged against a behavioural model that the bench compares on every clock.

// File: rtl/light_irq_pkg.sv
package light_irq_pkg;

    localparam int LIRQ_DW = 20;   // result and limit width
    localparam int LIRQ_PW = 4;    // persistence field width
    localparam int LIRQ_CW = 3;    // delta step code width
    localparam int LIRQ_SW = 2;    // channel select width

    typedef enum logic [LIRQ_SW-1:0] {
        SRC_CLEAR = 2'b00,
        SRC_ALS   = 2'b01,
        SRC_ALT2  = 2'b10,
        SRC_ALT3  = 2'b11
    } src_sel_e;

    typedef enum logic {
        TRIG_WINDOW = 1'b0,
        TRIG_DELTA  = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic               vld;
        logic [LIRQ_DW-1:0] val;
    } sample_t;

    // Channel pick: only the all-zero code selects the unfiltered channel.
    function automatic logic [LIRQ_DW-1:0] pick_channel(
        input src_sel_e           sel,
        input logic [LIRQ_DW-1:0] clr_v,
        input logic [LIRQ_DW-1:0] als_v
    );
        return (sel == SRC_CLEAR) ? clr_v : als_v;
    endfunction

endpackage

// File: rtl/lirq_qualify.sv
module lirq_qualify
    import light_irq_pkg::*;
#(
    parameter int DW = LIRQ_DW,
    parameter int CW = LIRQ_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  trig_mode_e    mode,
    input  logic          vld,
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] lo,
    input  logic [CW-1:0] code,
    output logic          qual
);

    localparam logic [DW-1:0] STEP_BASE = DW'(8);

    logic [DW-1:0] prev_q;
    logic          armed_q;
    trig_mode_e    mode_q;

    logic [DW-1:0] delta;
    logic [DW-1:0] step;
    logic          armed_now;
    logic          win_hit;
    logic          delta_hit;

    always_comb begin
        delta     = (val >= prev_q) ? (val - prev_q) : (prev_q - val);
        step      = STEP_BASE << code;
        armed_now = armed_q && (mode == mode_q);
        win_hit   = (val > hi) || (val < lo);
        delta_hit = armed_now && (delta > step);
        qual      = en && vld && ((mode == TRIG_DELTA) ? delta_hit : win_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
            mode_q  <= TRIG_WINDOW;
        end else begin
            mode_q <= mode;
            if (!en) begin
                armed_q <= 1'b0;
            end else if (vld) begin
                armed_q <= 1'b1;
                prev_q  <= val;
            end else if (mode != mode_q) begin
                armed_q <= 1'b0;
            end
        end
    end

    AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
        (en && vld && mode == TRIG_DELTA && !armed_q) |-> !qual); // R5

    AST_ARM_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (en && vld) |=> armed_q); // R5

endmodule

// File: rtl/lirq_persist.sv
module lirq_persist #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          vld,
    input  logic          qual,
    input  logic [PW-1:0] persist,
    output logic          fire
);

    localparam int CNTW = PW + 1;
    localparam logic [CNTW-1:0] CNT_MAX = CNTW'(1) << PW;

    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] target;
    logic [CNTW-1:0] bumped;

    always_comb begin
        target = CNTW'(persist) + CNTW'(1);
        bumped = cnt_q + CNTW'(1);
        fire   = qual && (bumped >= target);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (vld) begin
            if (qual) cnt_q <= (bumped > target) ? target : bumped;
            else      cnt_q <= '0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX); // R6

    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (en && vld && !qual) |=> (cnt_q == '0)); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/lirq_flag.sv
module lirq_flag (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fire,
    input  logic rd_clr,
    output logic flag,
    output logic pin_n
);

    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (fire)   flag <= 1'b1;
        else if (rd_clr) flag <= 1'b0;
    end

    always_comb pin_n = !(flag && en);

    AST_FIRE_SETS: assert property (@(posedge clk) disable iff (rst)
        fire |=> flag); // R10

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !fire) |=> !flag); // R8

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!fire && !rd_clr) |=> $stable(flag)); // R9

endmodule

// File: rtl/light_irq_ctrl.sv
module light_irq_ctrl
    import light_irq_pkg::*;
#(
    parameter int DW = LIRQ_DW,
    parameter int PW = LIRQ_PW,
    parameter int CW = LIRQ_CW,
    parameter int SW = LIRQ_SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_vld,
    input  logic [DW-1:0] clear_data,
    input  logic [DW-1:0] als_data,
    input  logic          irq_en,
    input  logic          var_mode,
    input  logic [SW-1:0] src_sel,
    input  logic [PW-1:0] persist,
    input  logic [DW-1:0] thr_hi,
    input  logic [DW-1:0] thr_lo,
    input  logic [CW-1:0] var_code,
    input  logic          stat_rd_clr,
    output logic          irq_flag,
    output logic          irq_n
);

    sample_t    smp;
    trig_mode_e mode;
    logic       qual_w;
    logic       fire_w;

    always_comb begin
        smp.vld = sample_vld;
        smp.val = pick_channel(src_sel_e'(src_sel), clear_data, als_data);
        mode    = trig_mode_e'(var_mode);
    end

    lirq_qualify #(.DW(DW), .CW(CW)) u_qualify (
        .clk  (clk),
        .rst  (rst),
        .en   (irq_en),
        .mode (mode),
        .vld  (smp.vld),
        .val  (smp.val),
        .hi   (thr_hi),
        .lo   (thr_lo),
        .code (var_code),
        .qual (qual_w)
    );

    lirq_persist #(.PW(PW)) u_persist (
        .clk     (clk),
        .rst     (rst),
        .en      (irq_en),
        .vld     (smp.vld),
        .qual    (qual_w),
        .persist (persist),
        .fire    (fire_w)
    );

    lirq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .en     (irq_en),
        .fire   (fire_w),
        .rd_clr (stat_rd_clr),
        .flag   (irq_flag),
        .pin_n  (irq_n)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !fire_w); // R2

    AST_WINDOW_ABOVE: assert property (@(posedge clk) disable iff (rst)
        (irq_en && sample_vld && !var_mode && (smp.val > thr_hi)) |-> qual_w); // R3

    AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_en) |-> irq_n); // R9

endmodule

// File: tb/light_irq_ctrl_tb.sv
module light_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_vld = 1'b0;
    logic [19:0] clear_data = '0;
    logic [19:0] als_data = '0;
    logic        irq_en = 1'b0;
    logic        var_mode = 1'b0;
    logic [1:0]  src_sel = 2'b01;
    logic [3:0]  persist = '0;
    logic [19:0] thr_hi = 20'hFFFFF;
    logic [19:0] thr_lo = '0;
    logic [2:0]  var_code = '0;
    logic        stat_rd_clr = 1'b0;
    logic        irq_flag;
    logic        irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    light_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .sample_vld(sample_vld), .clear_data(clear_data),
        .als_data(als_data), .irq_en(irq_en), .var_mode(var_mode), .src_sel(src_sel),
        .persist(persist), .thr_hi(thr_hi), .thr_lo(thr_lo), .var_code(var_code),
        .stat_rd_clr(stat_rd_clr), .irq_flag(irq_flag), .irq_n(irq_n)
    );

    // Behavioural reference model, updated on each rising edge
    int m_cnt = 0, m_prev = 0, m_armed = 0, m_modeq = 0, m_flag = 0;

    always @(posedge clk) begin
        int val, diff, step, tgt, q;
        if (rst) begin
            m_cnt = 0; m_prev = 0; m_armed = 0; m_modeq = 0; m_flag = 0;
        end else begin
            val  = (src_sel == 2'b00) ? int'(clear_data) : int'(als_data);
            diff = (val > m_prev) ? val - m_prev : m_prev - val;
            step = 8 * (1 << var_code);
            tgt  = int'(persist) + 1;
            q = 0;
            if (irq_en && sample_vld) begin
                if (!var_mode) q = (val > int'(thr_hi) || val < int'(thr_lo)) ? 1 : 0;
                else q = (m_armed != 0 && int'(var_mode) == m_modeq && diff > step) ? 1 : 0;
            end
            if (q != 0 && m_cnt + 1 >= tgt) m_flag = 1;
            else if (stat_rd_clr) m_flag = 0;
            if (!irq_en) m_cnt = 0;
            else if (sample_vld) m_cnt = (q != 0) ? ((m_cnt + 1 > tgt) ? tgt : m_cnt + 1) : 0;
            if (!irq_en) m_armed = 0;
            else if (sample_vld) begin m_armed = 1; m_prev = val; end
            else if (int'(var_mode) != m_modeq) m_armed = 0;
            m_modeq = int'(var_mode);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(irq_flag) != m_flag || int'(irq_n) != ((m_flag != 0 && irq_en) ? 0 : 1)) begin
                fails++;
                $display("FAIL R6/R9 model compare: flag=%0d pin=%0d expected flag=%0d pin=%0d",
                         irq_flag, irq_n, m_flag, (m_flag != 0 && irq_en) ? 0 : 1);
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step_idle();
        @(negedge clk); #1;
    endtask

    task automatic smp(input logic [19:0] c, input logic [19:0] a, input logic clr = 1'b0);
        @(negedge clk); #1;
        clear_data = c; als_data = a; sample_vld = 1'b1; stat_rd_clr = clr;
        @(negedge clk); #1;
        sample_vld = 1'b0; stat_rd_clr = 1'b0;
    endtask

    task automatic rd_clear();
        @(negedge clk); #1;
        stat_rd_clr = 1'b1;
        @(negedge clk); #1;
        stat_rd_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check("R1 flag after reset", irq_flag, 1'b0);
        check("R1 pin after reset", irq_n, 1'b1);
        rst = 1'b0;
        thr_hi = 20'd100; thr_lo = 20'd10;
        step_idle();

        // R2: disabled block ignores an out-of-window sample
        smp(0, 20'd500);
        check("R2 disabled sample", irq_flag, 1'b0);
        check("R2 disabled pin", irq_n, 1'b1);

        // R3 / R10: window mode, strict compare
        irq_en = 1'b1;
        smp(0, 20'd50);
        check("R3 inside window", irq_flag, 1'b0);
        smp(0, 20'd100);
        check("R3 equal to upper", irq_flag, 1'b0);
        smp(0, 20'd101);
        check("R10 above upper sets next edge", irq_flag, 1'b1);
        check("R9 pin low", irq_n, 1'b0);
        rd_clear();
        check("R8 read clears", irq_flag, 1'b0);
        check("R9 pin released", irq_n, 1'b1);
        smp(0, 20'd10);
        check("R3 equal to lower", irq_flag, 1'b0);
        smp(0, 20'd9);
        check("R3 below lower", irq_flag, 1'b1);
        rd_clear();

        // R7: channel select
        src_sel = 2'b00;
        smp(20'd500, 20'd50);
        check("R7 clear channel chosen", irq_flag, 1'b1);
        rd_clear();
        src_sel = 2'b10;
        smp(20'd500, 20'd50);
        check("R7 code 10 picks eye channel", irq_flag, 1'b0);
        src_sel = 2'b01;

        // R6: persistence of three, reset by a miss, saturation
        persist = 4'd2;
        smp(0, 20'd200); smp(0, 20'd200);
        check("R6 two of three", irq_flag, 1'b0);
        smp(0, 20'd50);
        smp(0, 20'd200); smp(0, 20'd200);
        check("R6 miss restarted count", irq_flag, 1'b0);
        smp(0, 20'd200);
        check("R6 third consecutive", irq_flag, 1'b1);
        rd_clear();
        smp(0, 20'd200);
        check("R6 saturated count refires", irq_flag, 1'b1);
        rd_clear();

        // R9: disable releases the pin, flag kept
        persist = 4'd0;
        smp(0, 20'd200);
        check("R9 flag set", irq_flag, 1'b1);
        irq_en = 1'b0;
        step_idle();
        check("R9 pin released on disable", irq_n, 1'b1);
        check("R9 flag kept on disable", irq_flag, 1'b1);
        rd_clear();

        // R4 / R5: delta mode
        irq_en = 1'b1; var_mode = 1'b1; var_code = 3'd0;
        smp(0, 20'd1000);
        check("R5 first sample after enable", irq_flag, 1'b0);
        smp(0, 20'd1008);
        check("R4 change of 8 with step 8", irq_flag, 1'b0);
        smp(0, 20'd1017);
        check("R4 change of 9 with step 8", irq_flag, 1'b1);
        rd_clear();
        var_code = 3'd7;
        smp(0, 20'd2041);
        check("R4 change of 1024 with code 7", irq_flag, 1'b0);
        smp(0, 20'd1016);
        check("R4 falling change of 1025", irq_flag, 1'b1);
        rd_clear();

        // R5: mode change disarms the reference
        var_mode = 1'b0;
        step_idle();
        var_mode = 1'b1;
        step_idle();
        smp(0, 20'd5000);
        check("R5 first sample after mode change", irq_flag, 1'b0);
        smp(0, 20'd5000);
        check("R4 no change", irq_flag, 1'b0);

        // R8: set and clear in the same cycle
        smp(0, 20'd7000);
        check("R4 change of 2000", irq_flag, 1'b1);
        smp(0, 20'd9000, 1'b1);
        check("R8 set wins over clear", irq_flag, 1'b1);
        rd_clear();
        check("R8 lone clear", irq_flag, 1'b0);

        repeat (3) step_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule